// File: doc/BRIEF.md
# Split Event Counter Bank

A bank of wide event counters that cost little area per counter. Each counter keeps only its low-order bits in a fast local register that increments on its own event input. The high-order bits of every counter share one memory array. A round-robin poller visits one counter per clock. When the visited counter has a pending overflow, the poller does a single read-modify-write on that counter's memory word.

Software reads the full value of any counter through a combinational read port. It programs a threshold and an enable per counter, and receives a sticky interrupt flag per counter. A counter's value changes only through reset or a global clear. There is no preset and no arbitrary write.

Top module: `evbank_top`

## Requirements
- R1: After reset every counter reads 0, and all bits of `irq_o` and `err_o` are 0.
- R2: Each clock in which `event_i[k]` is 1 adds one to counter k. `rd_data_o` shows the value of counter `rd_idx_i` as {high part, low part}, and that value equals the number of events seen since the last reset or clear.
- R3: A low-order wrap sets a sticky pending-carry bit. While that carry has not yet been moved into the memory word, the read result adds one to the high part, so the value read is never short.
- R4: An event that arrives in the same clock in which the poller takes that counter's carry is still counted.
- R5: The poller visits counter indices 0, 1, …, N-1 in order, one per clock, and then repeats. Each carry and each threshold test therefore happens within N clocks.
- R6: A counter raises its `irq_o` bit when its enable is 1 and the poller finds that the full value is greater than or equal to its threshold. The bit stays at 1 until it is cleared.
- R7: A counter whose enable is 0 never raises its `irq_o` bit, whatever its value.
- R8: Writing 1 to bit k of `irq_clr_i` clears `irq_o[k]` on the next clock. The clear wins over a set in the same clock. The bit is set again at a later visit if the value still meets the threshold.
- R9: If a counter wraps a second time while an earlier carry is still pending, its `err_o` bit sets and stays at 1 until clear. A carry taken in the same clock as the new wrap is not an error.
- R10: `clear_i` sets every counter to zero and clears every `err_o` bit. Events in the clear clock are dropped. `clear_i` leaves thresholds, enables and `irq_o` unchanged.
- R11: A clock with `cfg_we_i` at 1 writes `cfg_thr_i` and `cfg_en_i` to counter `cfg_idx_i` only. After reset every threshold is all ones and every enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | N_CNT | One increment input per counter |
| clear_i | input | 1 | Sets all counters to zero and clears all error flags |
| cfg_we_i | input | 1 | Strobe that writes the threshold and enable |
| cfg_idx_i | input | IDX_W | Counter selected by the configuration write |
| cfg_thr_i | input | LO_W+HI_W | Threshold value to write |
| cfg_en_i | input | 1 | Interrupt enable to write |
| irq_clr_i | input | N_CNT | Clears the matching interrupt flags (write one to clear) |
| rd_idx_i | input | IDX_W | Counter selected for reading |
| rd_data_o | output | LO_W+HI_W | Full value of the selected counter |
| irq_o | output | N_CNT | Sticky threshold interrupt flags |
| err_o | output | N_CNT | Sticky lost-carry error flags |

## Verification
The bench uses a small configuration with 8 counters and a 2-bit low part, so wraps and carries happen often. First it runs a long sweep. In that sweep each counter fires with its own period, so the counters pass through wraps out of step with the poller position. A read that rotates over all indices each clock shows whether the pending-carry correction and carries taken in the same clock as an event are both handled.

Then the bench drives several directed patterns:
- A threshold that lies just past a wrap.
- A value one below the threshold.
- A counter with its enable at 0.
- A W1C in the visit window.
- A clear in the same clock as events.
- A burst on one counter, fast enough to wrap twice within a single poll period.

Together these patterns separate interrupt timing, clear priority and error detection.

// File: rtl/evbank_pkg.sv
package evbank_pkg;
  localparam int unsigned DEF_N    = 16;
  localparam int unsigned DEF_LO_W = 12;
  localparam int unsigned DEF_HI_W = 52;
endpackage

// File: rtl/evbank_lo_cnt.sv
module evbank_lo_cnt #(
  parameter int unsigned LO_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            ev_i,
  input  logic            take_i,
  output logic [LO_W-1:0] lo_o,
  output logic            ovf_o,
  output logic            err_o
);
  logic wrap;
  assign wrap = ev_i && (lo_o == {LO_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_o  <= '0;
      ovf_o <= 1'b0;
      err_o <= 1'b0;
    end else if (clear_i) begin
      lo_o  <= '0;
      ovf_o <= 1'b0;
      err_o <= 1'b0;
    end else begin
      lo_o  <= lo_o + LO_W'(ev_i);
      ovf_o <= (ovf_o && !take_i) || wrap;
      if (wrap && ovf_o && !take_i) err_o <= 1'b1;
    end
  end

  assert_wrap_pends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !clear_i) |=> ovf_o);
  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clear_i) |=> err_o);
  assert_clear_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (lo_o == '0 && !ovf_o && !err_o));
endmodule

// File: rtl/evbank_hi_store.sv
module evbank_hi_store #(
  parameter int unsigned N     = 16,
  parameter int unsigned HI_W  = 52,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [HI_W-1:0]  wr_data_i,
  input  logic [IDX_W-1:0] pa_idx_i,
  output logic [HI_W-1:0]  pa_data_o,
  input  logic [IDX_W-1:0] pb_idx_i,
  output logic [HI_W-1:0]  pb_data_o
);
  logic [HI_W-1:0] mem [N];
  logic [N-1:0]    vld;  // word holds data since last clear; else reads as zero

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_idx_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld <= '0;
    else if (clear_i) vld <= '0;
    else if (wr_en_i) vld[wr_idx_i] <= 1'b1;
  end

  assign pa_data_o = vld[pa_idx_i] ? mem[pa_idx_i] : '0;
  assign pb_data_o = vld[pb_idx_i] ? mem[pb_idx_i] : '0;

  assert_wr_not_in_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |-> !wr_en_i);
endmodule

// File: rtl/evbank_poller.sv
module evbank_poller #(
  parameter int unsigned N     = 16,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [IDX_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ptr_o <= '0;
    else if (ptr_o == IDX_W'(N-1))  ptr_o <= '0;
    else                            ptr_o <= ptr_o + 1'b1;
  end

  assert_ptr_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o <= IDX_W'(N-1));
endmodule

// File: rtl/evbank_top.sv
module evbank_top #(
  parameter int unsigned N_CNT = evbank_pkg::DEF_N,
  parameter int unsigned LO_W  = evbank_pkg::DEF_LO_W,
  parameter int unsigned HI_W  = evbank_pkg::DEF_HI_W,
  localparam int unsigned IDX_W = (N_CNT > 1) ? $clog2(N_CNT) : 1,
  localparam int unsigned CNT_W = LO_W + HI_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CNT-1:0] event_i,
  input  logic             clear_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [CNT_W-1:0] cfg_thr_i,
  input  logic             cfg_en_i,
  input  logic [N_CNT-1:0] irq_clr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic [N_CNT-1:0] irq_o,
  output logic [N_CNT-1:0] err_o
);
  logic [N_CNT-1:0][LO_W-1:0]  lo;
  logic [N_CNT-1:0]            ovf;
  logic [N_CNT-1:0]            take_vec;
  logic [N_CNT-1:0][CNT_W-1:0] thr_q;
  logic [N_CNT-1:0]            en_q;
  logic [IDX_W-1:0]            ptr;
  logic [HI_W-1:0]             hi_poll, hi_rd;
  logic                        take, hit;
  logic [CNT_W-1:0]            poll_val;

  evbank_poller #(.N(N_CNT)) u_poll (.clk_i, .rst_ni, .ptr_o(ptr));

  assign take = ovf[ptr] && !clear_i;

  evbank_hi_store #(.N(N_CNT), .HI_W(HI_W)) u_hi (
    .clk_i, .rst_ni, .clear_i,
    .wr_en_i(take), .wr_idx_i(ptr), .wr_data_i(hi_poll + 1'b1),
    .pa_idx_i(ptr), .pa_data_o(hi_poll),
    .pb_idx_i(rd_idx_i), .pb_data_o(hi_rd)
  );

  for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
    assign take_vec[k] = take && (ptr == IDX_W'(k));

    evbank_lo_cnt #(.LO_W(LO_W)) u_lo (
      .clk_i, .rst_ni, .clear_i,
      .ev_i(event_i[k]), .take_i(take_vec[k]),
      .lo_o(lo[k]), .ovf_o(ovf[k]), .err_o(err_o[k])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        thr_q[k] <= '1;
        en_q[k]  <= 1'b0;
      end else if (cfg_we_i && cfg_idx_i == IDX_W'(k)) begin
        thr_q[k] <= cfg_thr_i;
        en_q[k]  <= cfg_en_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          irq_o[k] <= 1'b0;
      else if (irq_clr_i[k])                irq_o[k] <= 1'b0;
      else if (hit && ptr == IDX_W'(k))     irq_o[k] <= 1'b1;
    end

    assert_irq_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_clr_i[k] |=> !irq_o[k]);
    assert_irq_needs_en_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_q[k] && !irq_o[k]) |=> !irq_o[k]);
  end

  // full value includes a carry not yet moved to memory
  assign poll_val  = {hi_poll + HI_W'(ovf[ptr]), lo[ptr]};
  assign hit       = en_q[ptr] && (poll_val >= thr_q[ptr]);
  assign rd_data_o = {hi_rd + HI_W'(ovf[rd_idx_i]), lo[rd_idx_i]};

  assert_take_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !event_i[ptr]) |=> !ovf[$past(ptr)]);
endmodule

// File: tb/tb_evbank_top.sv
module tb_evbank_top;
  localparam int unsigned N     = 8;
  localparam int unsigned LO_W  = 2;
  localparam int unsigned HI_W  = 10;
  localparam int unsigned IDX_W = 3;
  localparam int unsigned CNT_W = LO_W + HI_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N-1:0]     event_s = '0;
  logic             clear_s = 1'b0;
  logic             cfg_we = 1'b0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [CNT_W-1:0] cfg_thr = '0;
  logic             cfg_en = 1'b0;
  logic [N-1:0]     irq_clr = '0;
  logic [IDX_W-1:0] rd_idx = '0;
  logic [CNT_W-1:0] rd_data;
  logic [N-1:0]     irq, err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int model [N];

  always #5 clk = ~clk;

  evbank_top #(.N_CNT(N), .LO_W(LO_W), .HI_W(HI_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .event_i(event_s), .clear_i(clear_s),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_thr_i(cfg_thr), .cfg_en_i(cfg_en),
    .irq_clr_i(irq_clr), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .irq_o(irq), .err_o(err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clear_s = 1'b1;
    @(negedge clk); clear_s = 1'b0;
    for (int k = 0; k < N; k++) model[k] = 0;
  endtask

  task automatic cfg(input int idx, input int thr, input bit en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_thr = CNT_W'(thr); cfg_en = en;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse_ev(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); event_s[idx] = 1'b1;
      @(negedge clk); event_s[idx] = 1'b0;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int k = 0; k < N; k++) begin
      rd_idx = IDX_W'(k); #1;
      chk("R1 read zero", 64'(rd_data), 64'd0);
    end
    chk("R1 irq", 64'(irq), 64'd0);
    chk("R1 err", 64'(err), 64'd0);

    // R2 R3 R4 R5 staggered sweep with rotating reads
    for (int k = 0; k < N; k++) model[k] = 0;
    for (int t = 0; t < 1500; t++) begin
      @(negedge clk);
      rd_idx = IDX_W'(t % N); #1;
      chk("R2 R3 R4 sweep value", 64'(rd_data), 64'(model[t % N]));
      for (int k = 0; k < N; k++) begin
        event_s[k] = ((t % (k + 2)) == 0);
        if (event_s[k]) model[k]++;
      end
    end
    @(negedge clk); event_s = '0;
    for (int k = 0; k < N; k++) begin
      rd_idx = IDX_W'(k); #1;
      chk("R2 final value", 64'(rd_data), 64'(model[k]));
    end
    chk("R9 no error at safe rate", 64'(err), 64'd0);
    chk("R11 no irq while disabled", 64'(irq), 64'd0);

    // R10 clear in same clock as events
    @(negedge clk); clear_s = 1'b1; event_s = '1;
    @(negedge clk); clear_s = 1'b0; event_s = '0;
    for (int k = 0; k < N; k++) begin
      model[k] = 0;
      rd_idx = IDX_W'(k); #1;
      chk("R10 cleared value", 64'(rd_data), 64'd0);
    end

    // R6 R11 threshold just past a wrap
    cfg(5, 13, 1'b1);
    pulse_ev(5, 12);
    idle(N + 1);
    chk("R6 below threshold", 64'(irq), 64'd0);
    pulse_ev(5, 1);
    rd_idx = 3'd5; #1;
    chk("R3 value 13", 64'(rd_data), 64'd13);
    idle(N + 1);
    chk("R6 R11 irq only on counter 5", 64'(irq), 64'h20);

    // R8 W1C priority, re-set, then clear stays
    @(negedge clk); irq_clr = 8'h20;
    @(negedge clk); irq_clr = '0;
    chk("R8 cleared next clock", 64'(irq[5]), 64'd0);
    idle(N + 1);
    chk("R8 set again while value meets threshold", 64'(irq[5]), 64'd1);
    cfg(5, 100, 1'b1);
    @(negedge clk); irq_clr = 8'h20;
    @(negedge clk); irq_clr = '0;
    idle(N + 1);
    chk("R8 stays clear after threshold raised", 64'(irq[5]), 64'd0);

    // R7 disabled counter with value past threshold
    cfg(6, 1, 1'b0);
    pulse_ev(6, 3);
    idle(N + 1);
    chk("R7 disabled no irq", 64'(irq[6]), 64'd0);

    // R10 clear keeps irq, R9 double wrap
    cfg(2, 1, 1'b1);
    pulse_ev(2, 1);
    idle(N + 1);
    chk("R6 counter 2 irq", 64'(irq[2]), 64'd1);
    do_clear();
    chk("R10 clear keeps irq", 64'(irq[2]), 64'd1);
    @(negedge clk); event_s[3] = 1'b1;
    idle(20);
    event_s[3] = 1'b0;
    @(negedge clk);
    chk("R9 error on double wrap", 64'(err), 64'h08);
    idle(N + 1);
    chk("R9 error sticky", 64'(err), 64'h08);
    do_clear();
    chk("R10 error cleared", 64'(err), 64'd0);
    rd_idx = 3'd3; #1;
    chk("R10 counter 3 zero", 64'(rd_data), 64'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule